// File: doc/BRIEF.md
# Two-Channel Timer Capture/Compare Unit

This block holds two timer channels that share one free-running up-counter. Each channel can capture the counter value on an edge at its pin, or compare the counter against a stored value and set, clear or toggle its output pin on a match. Each channel has a small control word. A two-bit edge/level field and two mode bits in that word select the function. Channel 0 can also take over channel 1 to form one buffered compare/PWM output. In that mode channel 1's value register acts as a second buffer slot.

Software reaches the block through a simple register port. Address 0 is channel 0's control word, address 1 is channel 1's, address 2 is channel 0's value register and address 3 is channel 1's. Two counter controls are provided: one halts counting and one holds the counter at zero. The mode bits can only change while both controls are asserted. Each channel drives a pin output with its own output-enable and raises an event flag.

Top module: `tmr_cc_pair`

## Requirements
- R1: When a channel's edge/level field (control bits 1:0) is 00, its pin_oe is low. One clock later its pin_out shows the preset level: low if mode-A (bit 2) is 1, high if it is 0. That level is kept when a compare action is then enabled.
- R2: Mode-A (bit 2) and mode-B (bit 3, channel 0 only) change on a control write only while tmr_stop and tmr_clr are both high. At other times these bits keep their values, while the edge/level field is still written.
- R3: With mode bits 00 and field 01, 10 or 11, the channel captures on a rising, falling or either edge of its pin. The pin passes a two-flop synchronizer. The value register receives the counter value two counts past the one present when the pin changed, the flag is set and pin_oe stays low.
- R4: With mode-A = 1, a match happens when the counter advances from the value in the channel's register. On a match, field 01 toggles pin_out, 10 clears it and 11 sets it. pin_oe is high and the flag is set. With field 00 the match sets only the flag, and the pin is not driven.
- R5: With mode-B set in channel 0, channel 1's control word reads as zero and ignores writes, and pin_oe[1] is low. Channel 0 drives its pin with the action its field selects.
- R6: In buffered mode the active compare value comes from whichever value register (address 2 or 3) was written last. It is loaded only on counter overflow or while tmr_clr is high, so a write made mid-period does not affect the period in progress.
- R7: In a compare mode, the overflow step (counter leaving all-ones) forces pin_out high for the clear action and low for the set action. A match at the same step is applied after this and so takes effect.
- R8: The flag (control bit 7) clears on a control write with bit 7 = 0 only if the word was read with the flag at 1 since the flag was last cleared. A write of 0 without such a read leaves the flag set.
- R9: The counter goes to zero on the clock after tmr_clr is high. It holds when only tmr_stop is high. Otherwise it adds one per clock and wraps from all-ones to zero.
- R10: After reset, all control fields, flags and the counter are zero, pin_oe is low and pin_out is high.
- R11: rdata shows the addressed register on the clock after rd_en, using the address map 0/1 control, 2/3 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | W | Write data |
| rdata | output | W | Registered read data |
| tmr_stop | input | 1 | Halt the counter |
| tmr_clr | input | 1 | Hold the counter at zero |
| pin_in | input | 2 | Channel pin inputs |
| pin_out | output | 2 | Channel pin outputs |
| pin_oe | output | 2 | Channel pin output-enables |
| flag | output | 2 | Channel event flags |
| cnt_o | output | W | Counter value |

## Verification
The assertions check the following on every cycle: mode bits change only in a cycle that follows stop-and-clear, a released channel or a disabled channel 1 never enables its pin, the counter holds or clears as commanded, and the reset state is correct. Only the bench scenarios can show the timing and value side of the design. This covers the two-stage synchronizer delay in captured values, edge selection for each field code, the set/clear/toggle waveforms and the forcing at overflow. It also covers the buffered compare value, which switches exactly at overflow, and the read-before-clear rule for the flags.

// File: rtl/tmr_cc_pkg.sv
package tmr_cc_pkg;

  typedef struct packed {
    logic       mb;
    logic       ma;
    logic [1:0] els;
  } chan_cfg_t;

  localparam logic [1:0] ELS_OFF = 2'b00;
  localparam logic [1:0] ELS_TGL = 2'b01;
  localparam logic [1:0] ELS_CLR = 2'b10;
  localparam logic [1:0] ELS_SET = 2'b11;

  localparam logic [1:0] ADR_CTL0 = 2'd0;
  localparam logic [1:0] ADR_VAL0 = 2'd2;
  localparam logic [1:0] ADR_VAL1 = 2'd3;

  localparam int FLAG_BIT = 7;

endpackage

// File: rtl/tmr_cc_counter.sv
module tmr_cc_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         stop_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o,
  output logic         tick_o,
  output logic         ovf_o
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  assign tick_o = !stop_i && !clr_i;
  assign ovf_o  = tick_o && (cnt_o == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt_o <= '0;
    else if (tick_o)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/tmr_cc_chan.sv
module tmr_cc_chan
  import tmr_cc_pkg::*;
#(
  parameter int W      = 8,
  parameter bit HAS_MB = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cnt_i,
  input  logic         tick_i,
  input  logic         ovf_i,
  input  logic         unlock_i,
  input  logic         dis_i,
  input  logic         buf_i,
  input  logic [W-1:0] act_i,
  input  logic         pin_i,
  input  logic         ctl_we_i,
  input  logic         ctl_re_i,
  input  logic         val_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] ctl_o,
  output logic [W-1:0] val_o,
  output chan_cfg_t    cfg_o,
  output logic         flag_o,
  output logic         pin_o,
  output logic         oe_o
);
  logic [1:0]   pin_sync;
  logic         pin_prev;
  chan_cfg_t    cfg_q;
  logic         armed_q;
  logic         rise, fall, cap_mode, cmp_mode, drive, match;
  logic         cap_hit, event_hit, clr_req, out_nxt;
  logic [W-1:0] cmp_val;

  assign rise     = pin_sync[1] & ~pin_prev;
  assign fall     = ~pin_sync[1] & pin_prev;
  assign cap_mode = !dis_i && !cfg_q.mb && !cfg_q.ma && (cfg_q.els != ELS_OFF);
  assign cmp_mode = !dis_i && (cfg_q.ma || cfg_q.mb);
  assign drive    = cmp_mode && (cfg_q.els != ELS_OFF);
  assign cmp_val  = buf_i ? act_i : val_o;
  assign match    = tick_i && (cnt_i == cmp_val);
  assign clr_req  = ctl_we_i && !dis_i && armed_q && !wdata_i[FLAG_BIT];
  assign event_hit = cap_hit || (cmp_mode && match);
  assign cfg_o    = cfg_q;

  always_comb begin
    unique case (cfg_q.els)
      ELS_TGL: cap_hit = cap_mode && rise;
      ELS_CLR: cap_hit = cap_mode && fall;
      ELS_SET: cap_hit = cap_mode && (rise || fall);
      default: cap_hit = 1'b0;
    endcase
  end

  always_comb begin
    out_nxt = pin_o;
    if (!dis_i) begin
      if (cfg_q.els == ELS_OFF) begin
        out_nxt = ~cfg_q.ma;
      end else if (drive) begin
        if (ovf_i && cfg_q.els == ELS_CLR) out_nxt = 1'b1;
        if (ovf_i && cfg_q.els == ELS_SET) out_nxt = 1'b0;
        if (match) begin
          unique case (cfg_q.els)
            ELS_TGL: out_nxt = ~out_nxt;
            ELS_CLR: out_nxt = 1'b0;
            default: out_nxt = 1'b1;
          endcase
        end
      end
    end
  end

  always_comb begin
    ctl_o = '0;
    if (!dis_i) begin
      ctl_o[FLAG_BIT] = flag_o;
      ctl_o[3]        = cfg_q.mb;
      ctl_o[2]        = cfg_q.ma;
      ctl_o[1:0]      = cfg_q.els;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_sync <= '0;
      pin_prev <= 1'b0;
    end else begin
      pin_sync <= {pin_sync[0], pin_i};
      pin_prev <= pin_sync[1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (ctl_we_i && !dis_i) begin
      cfg_q.els <= wdata_i[1:0];
      if (unlock_i) begin
        cfg_q.ma <= wdata_i[2];
        cfg_q.mb <= HAS_MB ? wdata_i[3] : 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (event_hit)    flag_o <= 1'b1;
      else if (clr_req) flag_o <= 1'b0;
      if (clr_req)                              armed_q <= 1'b0;
      else if (ctl_re_i && flag_o && !dis_i)    armed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      val_o <= '0;
      pin_o <= 1'b1;
      oe_o  <= 1'b0;
    end else begin
      if (cap_hit)       val_o <= cnt_i;
      else if (val_we_i) val_o <= wdata_i;
      pin_o <= out_nxt;
      oe_o  <= drive;
    end
  end
endmodule

// File: rtl/tmr_cc_pair.sv
module tmr_cc_pair
  import tmr_cc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic         tmr_stop,
  input  logic         tmr_clr,
  input  logic [1:0]   pin_in,
  output logic [1:0]   pin_out,
  output logic [1:0]   pin_oe,
  output logic [1:0]   flag,
  output logic [W-1:0] cnt_o
);
  localparam int NCH = 2;

  logic [W-1:0]         cnt, act_q;
  logic                 tick, ovf, unlock, buf_on, last_sel;
  logic [W-1:0]         ctl_rd [NCH];
  logic [W-1:0]         val_rd [NCH];
  chan_cfg_t [NCH-1:0]  cfg_w;

  assign unlock = tmr_stop && tmr_clr;
  assign buf_on = cfg_w[0].mb;
  assign cnt_o  = cnt;

  tmr_cc_counter #(.W(W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .stop_i (tmr_stop),
    .clr_i  (tmr_clr),
    .cnt_o  (cnt),
    .tick_o (tick),
    .ovf_o  (ovf)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    tmr_cc_chan #(.W(W), .HAS_MB(g == 0)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .cnt_i    (cnt),
      .tick_i   (tick),
      .ovf_i    (ovf),
      .unlock_i (unlock),
      .dis_i    ((g != 0) && buf_on),
      .buf_i    ((g == 0) && buf_on),
      .act_i    (act_q),
      .pin_i    (pin_in[g]),
      .ctl_we_i (wr_en && (addr == ADR_CTL0 + 2'(g))),
      .ctl_re_i (rd_en && (addr == ADR_CTL0 + 2'(g))),
      .val_we_i (wr_en && (addr == ADR_VAL0 + 2'(g))),
      .wdata_i  (wdata),
      .ctl_o    (ctl_rd[g]),
      .val_o    (val_rd[g]),
      .cfg_o    (cfg_w[g]),
      .flag_o   (flag[g]),
      .pin_o    (pin_out[g]),
      .oe_o     (pin_oe[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_sel <= 1'b0;
      act_q    <= '0;
    end else begin
      if (ovf || tmr_clr) act_q <= last_sel ? val_rd[1] : val_rd[0];
      if (wr_en && addr == ADR_VAL0)      last_sel <= 1'b0;
      else if (wr_en && addr == ADR_VAL1) last_sel <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      unique case (addr)
        2'd0:    rdata <= ctl_rd[0];
        2'd1:    rdata <= ctl_rd[1];
        2'd2:    rdata <= val_rd[0];
        default: rdata <= val_rd[1];
      endcase
    end
  end
endmodule

// File: rtl/tmr_cc_pair_chk.sv
module tmr_cc_pair_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         tmr_stop,
  input logic         tmr_clr,
  input logic [W-1:0] cnt_o,
  input logic [1:0]   pin_oe,
  input logic [1:0]   flag,
  input logic [7:0]   cfg_w
);
  // R2: mode bits move only after a stop-and-clear cycle
  a_r2_mode_locked: assert property (@(posedge clk) disable iff (rst)
    ((cfg_w[2] != $past(cfg_w[2])) || (cfg_w[3] != $past(cfg_w[3])) ||
     (cfg_w[6] != $past(cfg_w[6]))) |-> $past(tmr_stop && tmr_clr));

  a_r1_release_ch0: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_w[1:0] == 2'b00) |-> !pin_oe[0]);

  a_r1_release_ch1: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_w[5:4] == 2'b00) |-> !pin_oe[1]);

  a_r5_buf_ch1_off: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_w[3]) |-> !pin_oe[1]);

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    $past(tmr_stop && !tmr_clr) |-> (cnt_o == $past(cnt_o)));

  a_r9_clear: assert property (@(posedge clk) disable iff (rst)
    $past(tmr_clr) |-> (cnt_o == '0));

  a_r10_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cfg_w == 8'h00 && pin_oe == 2'b00 && flag == 2'b00));
endmodule

bind tmr_cc_pair tmr_cc_pair_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tmr_stop (tmr_stop),
  .tmr_clr  (tmr_clr),
  .cnt_o    (cnt_o),
  .pin_oe   (pin_oe),
  .flag     (flag),
  .cfg_w    (cfg_w)
);

// File: tb/tmr_cc_pair_bench.sv
`timescale 1ns/1ps
module tmr_cc_pair_bench;
  localparam int W    = 8;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]   addr = '0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic         tmr_stop = 1'b1, tmr_clr = 1'b1;
  logic [1:0]   pin_in = '0;
  logic [1:0]   pin_out, pin_oe, flag;
  logic [W-1:0] cnt_o;

  int n_chk = 0, n_bad = 0;
  int m_val [2];
  bit m_last;
  bit m_out;

  always #4 clk = ~clk;

  tmr_cc_pair #(.W(W)) u_tmr_cc_pair (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tmr_stop(tmr_stop), .tmr_clr(tmr_clr),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .flag(flag),
    .cnt_o(cnt_o)
  );

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [W-1:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output int v);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = int'(rdata);
  endtask

  // Per-cycle model of channel 0 in a compare mode (R4, R6, R7)
  task automatic lockstep(int els, bit bufm, int ncyc, int wk, int wa, int wv,
                          output int bad);
    int act, c, cmpv;
    bit nx;
    bad = 0;
    act = m_last ? m_val[1] : m_val[0];
    for (int k = 0; k < ncyc; k++) begin
      c = int'(cnt_o);
      if (k == wk) begin wr_en = 1'b1; addr = 2'(wa); wdata = W'(wv); end
      else wr_en = 1'b0;
      cmpv = bufm ? act : m_val[0];
      nx = m_out;
      if (c == MAXV && els == 2) nx = 1'b1;
      if (c == MAXV && els == 3) nx = 1'b0;
      if (c == cmpv) begin
        if (els == 1) nx = ~nx;
        else if (els == 2) nx = 1'b0;
        else if (els == 3) nx = 1'b1;
      end
      if (bufm && c == MAXV) act = m_last ? m_val[1] : m_val[0];
      if (k == wk) begin m_val[wa-2] = wv; m_last = (wa == 3); end
      @(negedge clk);
      if (pin_out[0] !== nx || pin_oe[0] !== 1'b1) bad++;
      m_out = nx;
    end
    wr_en = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    int v, c, bad, cmp;
    bit hit;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 counter", int'(cnt_o), 0);
    chk("R10 pin_oe", int'(pin_oe), 0);
    chk("R10 pin_out", int'(pin_out), 3);
    chk("R10 flags", int'(flag), 0);
    rd(2'd0, v); chk("R10 R11 ctrl0 read", v, 0);
    rd(2'd1, v); chk("R10 R11 ctrl1 read", v, 0);

    // R9 counter hold, run, wrap, clear
    tmr_clr = 1'b0;
    cyc(5); chk("R9 hold while stopped", int'(cnt_o), 0);
    tmr_stop = 1'b0;
    cyc(10); chk("R9 count", int'(cnt_o), 10);
    cyc(MAXV + 1); chk("R9 wrap", int'(cnt_o), 10);
    tmr_clr = 1'b1;
    cyc(1); chk("R9 clear", int'(cnt_o), 0);
    tmr_stop = 1'b1;

    // R2 mode lock
    tmr_clr = 1'b0;
    wr(2'd0, 8'h05); rd(2'd0, v); chk("R2 mode write ignored", v, 8'h01);
    tmr_clr = 1'b1;
    wr(2'd0, 8'h05); rd(2'd0, v); chk("R2 mode write accepted", v, 8'h05);

    // R1 release with preset level
    wr(2'd0, 8'h04); cyc(1);
    chk("R1 preset low", int'(pin_out[0]), 0);
    chk("R1 released low", int'(pin_oe[0]), 0);
    wr(2'd0, 8'h00); cyc(1);
    chk("R1 preset high", int'(pin_out[0]), 1);
    chk("R1 released high", int'(pin_oe[0]), 0);

    // R3 capture sweep on channel 1
    for (int els = 1; els <= 3; els++) begin
      for (int dir = 0; dir <= 1; dir++) begin
        tmr_stop = 1'b1; tmr_clr = 1'b1;
        pin_in[1] = dir[0];
        wr(2'd1, 8'(els));
        cyc(4);
        rd(2'd1, v); wr(2'd1, 8'(els));
        tmr_clr = 1'b0; tmr_stop = 1'b0;
        cyc(3);
        c = int'(cnt_o);
        pin_in[1] = ~pin_in[1];
        cyc(4);
        hit = (els == 3) || (els == 1 && dir == 0) || (els == 2 && dir == 1);
        chk($sformatf("R3 flag els%0d dir%0d", els, dir), int'(flag[1]), int'(hit));
        chk("R3 capture pin released", int'(pin_oe[1]), 0);
        if (hit) begin
          rd(2'd3, v);
          chk($sformatf("R3 captured value els%0d", els), v, (c + 2) % (MAXV + 1));
        end
      end
    end

    // R8 flag clear protocol (channel 1 flag is set from the last capture)
    tmr_stop = 1'b1; tmr_clr = 1'b1;
    wr(2'd1, 8'h03); cyc(1);
    chk("R8 write without read keeps flag", int'(flag[1]), 1);
    rd(2'd1, v); chk("R8 flag bit reads 1", (v >> 7) & 1, 1);
    wr(2'd1, 8'h03);
    chk("R8 read then write clears", int'(flag[1]), 0);

    // R4 / R7 unbuffered compare actions on channel 0
    for (int els = 1; els <= 3; els++) begin
      tmr_stop = 1'b1; tmr_clr = 1'b1;
      cmp = 8'h40 + els * 8'h10;
      wr(2'd0, 8'h04); cyc(1);
      wr(2'd2, 8'(cmp));
      wr(2'd0, 8'(4 + els));
      rd(2'd0, v); wr(2'd0, 8'(4 + els));
      m_val[0] = cmp; m_last = 1'b0; m_out = 1'b0;
      cyc(2);
      chk("R1 R4 preset kept after enable", int'(pin_out[0]), 0);
      chk("R4 pin driven", int'(pin_oe[0]), 1);
      tmr_clr = 1'b0; tmr_stop = 1'b0;
      lockstep(els, 1'b0, 600, -1, 2, 0, bad);
      chk($sformatf("R4 R7 waveform els%0d", els), bad, 0);
      chk("R4 compare flag", int'(flag[0]), 1);
    end

    // R4 software-only compare
    tmr_stop = 1'b1; tmr_clr = 1'b1;
    wr(2'd0, 8'h04);
    rd(2'd0, v); wr(2'd0, 8'h04);
    chk("R4 flag cleared before soft compare", int'(flag[0]), 0);
    tmr_clr = 1'b0; tmr_stop = 1'b0;
    cyc(MAXV + 10);
    chk("R4 soft compare flag", int'(flag[0]), 1);
    chk("R4 soft compare no drive", int'(pin_oe[0]), 0);
    chk("R4 soft compare pin level", int'(pin_out[0]), 0);

    // R5 / R6 buffered PWM
    tmr_stop = 1'b1; tmr_clr = 1'b1;
    wr(2'd0, 8'h04); cyc(1);
    wr(2'd2, 8'h20);
    wr(2'd0, 8'h0A);
    wr(2'd1, 8'h07);
    rd(2'd1, v); chk("R5 ctrl1 reads zero", v, 0);
    rd(2'd0, v); chk("R5 ctrl0 buffered mode", v & 8'h0F, 8'h0A);
    cyc(2);
    chk("R5 ch1 pin released", int'(pin_oe[1]), 0);
    chk("R5 ch0 start level", int'(pin_out[0]), 0);
    m_val[0] = 8'h20; m_val[1] = 0; m_last = 1'b0; m_out = 1'b0;
    tmr_clr = 1'b0; tmr_stop = 1'b0;
    lockstep(2, 1'b1, 900, 100, 3, 8'h80, bad);
    chk("R6 R7 buffer slot 1 switch at overflow", bad, 0);
    lockstep(2, 1'b1, 700, 60, 2, 8'h30, bad);
    chk("R6 R7 buffer slot 0 switch at overflow", bad, 0);
    chk("R5 ch1 still released", int'(pin_oe[1]), 0);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule